// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is the data path of an eight-pin general-purpose I/O port. A direction register chooses, pin by pin, whether the pin is driven by software or sampled from outside. Software reaches the data register through a window of 256 word addresses. Byte address bits [9:2] of each access form a per-pin mask. One bus access can therefore read or update any chosen subset of pins. No read-modify-write sequence is needed, so two software agents that own different pins cannot corrupt each other's bits.

Pins set as inputs are brought through a two-flop synchronizer, and their data bits then follow the external level. Pins set as outputs hold whatever software last wrote through the masked window. Input pins present a logic 1 on the output bus, as if pulled high, and their output enable is low. Reads return data one clock after the access.

Top module: `gpio_mask_port`

## Requirements
- R1: While `rst_n` is low and after reset, the data and direction registers are 0, so `pin_oe` is 0x00, `pin_out` is 0xFF and `bus_rdata` is 0x00.
- R2: Every byte offset below 0x400 addresses the data register, with the pin mask taken from `bus_addr[9:2]` (mask bit i selects pin i).
- R3: A read (`bus_sel`=1, `bus_wr`=0) in the data window returns the data register ANDed with the mask on `bus_rdata` after the next rising clock edge, and masked-off bits read as 0. `bus_rdata` holds its value until the next read.
- R4: A write in the data window changes data bit i only when mask bit i is 1 and direction bit i is 1. All other output-pin bits keep their value.
- R5: Offset 0x400 holds the direction register. A 1 in bit i makes pin i an output and a 0 makes it an input. It is written with `bus_wdata` and read back whole.
- R6: For an input pin, the data bit takes the level of `pin_in` on the third rising edge after that level is applied (two synchronizer flops, then the data register).
- R7: `pin_oe` equals the direction register. For each pin, `pin_out` is the data bit when the pin is an output and 1 when it is an input.
- R8: A write to any offset other than the data window or 0x400 changes no state. A read at such an offset returns 0x00.
- R9: A software write never changes the data bit of an input pin, even when its mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid after the edge that takes the read |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Level driven to the pins |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench writes through masks that mix output and input pins. A design that ignored the direction gate would overwrite sampled input bits, and one that ignored the mask would disturb neighbouring outputs. It reads back through narrow masks and through the all-zero mask at offset 0. A design that returned unmasked data would show stray ones there. It also checks the exact three-edge latency of input sampling, and that offsets next to the direction register are inert. A decoder that matched too loosely would then alias the direction register or the data window.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  // Which register an access lands on
  typedef enum logic [1:0] {
    RGN_DATA = 2'd0,
    RGN_DIR  = 2'd1,
    RGN_NONE = 2'd2
  } region_e;

  // Low byte-address bits below the word index
  localparam int unsigned WORD_LSB = 2;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q <= 1'b0;
        stage2_q <= 1'b0;
      end else begin
        stage1_q <= async_in[i];
        stage2_q <= stage1_q;
      end
    end

    assign sync_out[i] = stage2_q;
  end

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PINS   = 8,
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [PINS-1:0]   mask
);

  // The data window spans 2**PINS words; the direction register follows it
  localparam int unsigned WIN_TOP = PINS + WORD_LSB;
  localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << WIN_TOP;

  logic in_window;
  logic unused_low;

  assign in_window  = (addr[ADDR_W-1:WIN_TOP] == '0);
  assign mask       = addr[WIN_TOP-1:WORD_LSB];
  assign unused_low = ^addr[WORD_LSB-1:0];

  always_comb begin
    if (in_window) begin
      region = RGN_DATA;
    end else if (addr == DIR_OFF) begin
      region = RGN_DIR;
    end else begin
      region = RGN_NONE;
    end
  end

endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  logic [PINS-1:0] sw_mask,
  input  logic [PINS-1:0] sw_wdata,
  input  logic [PINS-1:0] dir,
  input  logic [PINS-1:0] pin_sync,
  output logic [PINS-1:0] data_q
);

  logic [PINS-1:0] wr_bits;
  logic [PINS-1:0] data_d;
  logic            data_en;

  always_comb begin
    // Software reaches only selected bits of pins that are outputs
    wr_bits = {PINS{sw_we}} & sw_mask & dir;
    data_d  = (~dir & pin_sync)
            | (wr_bits & sw_wdata)
            | (dir & ~wr_bits & data_q);
    data_en = sw_we | (|(~dir & (pin_sync ^ data_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PINS   = 8,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);

  region_e         region;
  logic [PINS-1:0] mask;
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] data_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] dir_d;
  logic            dir_en;
  logic [PINS-1:0] rd_q;
  logic [PINS-1:0] rd_d;
  logic            rd_en;
  logic            data_we;

  gpio_addr_decode #(.PINS(PINS), .ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .region (region),
    .mask   (mask)
  );

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  assign data_we = bus_sel & bus_wr & (region == RGN_DATA);

  gpio_data_reg #(.PINS(PINS)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (data_we),
    .sw_mask  (mask),
    .sw_wdata (bus_wdata),
    .dir      (dir_q),
    .pin_sync (pin_sync),
    .data_q   (data_q)
  );

  // Direction register
  always_comb begin
    dir_en = bus_sel & bus_wr & (region == RGN_DIR);
    dir_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  // Registered read data
  always_comb begin
    rd_en = bus_sel & ~bus_wr;
    unique case (region)
      RGN_DATA: rd_d = data_q & mask;
      RGN_DIR:  rd_d = dir_q;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign bus_rdata = rd_q;
  assign pin_oe    = dir_q;
  assign pin_out   = (data_q & dir_q) | ~dir_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int unsigned PINS   = 8,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   data_q,
  input logic [PINS-1:0]   dir_q
);

  localparam int unsigned WIN_TOP = PINS + 2;
  localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << WIN_TOP;

  logic            in_win;
  logic            at_dir;
  logic [PINS-1:0] amask;

  assign in_win = (bus_addr[ADDR_W-1:WIN_TOP] == '0);
  assign at_dir = (bus_addr == DIR_OFF);
  assign amask  = bus_addr[WIN_TOP-1:2];

  // R1: reset holds every pin as an input
  p_reset_oe_r1: assert property (@(posedge clk) !rst_n |-> (pin_oe == '0 && bus_rdata == '0));

  // R7: input pins always present a 1
  p_input_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pin_oe & ~pin_out) == '0));

  // R3: masked-off bits of a data read come back as 0
  p_read_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && in_win) |=> ((bus_rdata & ~$past(amask)) == '0));

  // R8: reads at unmapped offsets return 0
  p_bad_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !in_win && !at_dir) |=> (bus_rdata == '0));

  // R4: output bits outside the mask survive a data write
  p_unmasked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && in_win) |=>
      (((data_q ^ $past(data_q)) & $past(dir_q & ~amask)) == '0));

  // R4: output bits hold when no data write happens
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && in_win) |=>
      (((data_q ^ $past(data_q)) & $past(dir_q)) == '0));

  // R5: a write at the direction offset loads the direction register
  p_dir_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && at_dir) |=> (pin_oe == $past(bus_wdata)));

  // R8: direction only changes through its own offset
  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && at_dir) |=> $stable(pin_oe));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .data_q    (data_q),
  .dir_q     (dir_q)
);

// File: tb/tb_gpio_mask_port.sv
`timescale 1ns/1ps
module tb_gpio_mask_port;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  gpio_mask_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference: a pin-level history plus the two registers
  logic [7:0] pin_hist [$];
  logic [7:0] m_data, m_dir, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 8'h00; m_dir = 8'h00; m_rd = 8'h00;
      pin_hist = {8'h00, 8'h00};
    end else begin
      logic [7:0] seen, nd, msk;
      bit win;
      win  = (bus_addr < 12'h400);
      msk  = bus_addr[9:2];
      seen = pin_hist[0];
      nd   = m_data;
      for (int i = 0; i < 8; i++) begin
        if (!m_dir[i]) nd[i] = seen[i];
        else if (bus_sel && bus_wr && win && msk[i]) nd[i] = bus_wdata[i];
      end
      if (bus_sel && !bus_wr)
        m_rd = win ? (m_data & msk) : (bus_addr == 12'h400) ? m_dir : 8'h00;
      if (bus_sel && bus_wr && bus_addr == 12'h400) m_dir = bus_wdata;
      m_data = nd;
      void'(pin_hist.pop_front());
      pin_hist.push_back(pin_in);
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 pin_oe", pin_oe, m_dir);
      chk("R7 pin_out", pin_out, (m_data & m_dir) | ~m_dir);
      chk("R3 bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; pin_in = 8'h00;
    #1;
    chk("R1 pin_oe in reset", pin_oe, 8'h00);
    chk("R1 pin_out in reset", pin_out, 8'hFF);
    idle(3);
    chk("R1 rdata in reset", bus_rdata, 8'h00);
    rst_n = 1;
    idle(2);
    rd(12'h3FC, 8'h00, "R1 data after reset");
    rd(12'h400, 8'h00, "R1 dir after reset");

    // R6: input latency of exactly three edges
    @(negedge clk); pin_in = 8'hA5;
    @(negedge clk); @(negedge clk);
    @(negedge clk);
    rd(12'h3FC, 8'hA5, "R6 input sampled");

    // R5: direction write and readback
    pin_in = 8'h50;
    wr(12'h400, 8'h0F);
    rd(12'h400, 8'h0F, "R5 dir readback");
    idle(4);

    // R9: full-mask write does not touch input bits
    wr(12'h3FC, 8'hFF);
    rd(12'h3FC, 8'h5F, "R9 inputs kept");
    // R4: single-bit and two-bit masked writes
    wr(12'h004, 8'h00);
    rd(12'h3FC, 8'h5E, "R4 bit0 cleared");
    wr(12'h0C0, 8'hFF);
    rd(12'h3FC, 8'h5E, "R9 masked input bits unchanged");
    wr(12'h018, 8'h00);
    rd(12'h3FC, 8'h58, "R4 bits1-2 cleared");
    // R3 / R2: narrow masks and the zero mask
    rd(12'h03C, 8'h08, "R3 low-nibble mask");
    rd(12'h000, 8'h00, "R2 zero mask");
    rd(12'h140, 8'h50, "R2 mask 0x50");
    chk("R7 pin_out", pin_out, 8'hF8);
    chk("R7 pin_oe", pin_oe, 8'h0F);

    // R8: unmapped offsets
    wr(12'h404, 8'hFF);
    wr(12'h800, 8'hFF);
    rd(12'h404, 8'h00, "R8 read unmapped");
    rd(12'hFFC, 8'h00, "R8 read high unmapped");
    rd(12'h400, 8'h0F, "R8 dir untouched");
    rd(12'h3FC, 8'h58, "R8 data untouched");

    // Output kept when pin turns input then back
    wr(12'h400, 8'hFF);
    wr(12'h3FC, 8'h3C);
    rd(12'h3FC, 8'h3C, "R4 all outputs");
    chk("R7 all-output pins", pin_out, 8'h3C);

    // Random traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      bus_sel = $urandom_range(0, 1);
      bus_wr  = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: bus_addr = 12'h400;
        1: bus_addr = 12'h400 + 12'($urandom_range(1, 8) * 4);
        default: bus_addr = 12'($urandom_range(0, 255) * 4);
      endcase
      bus_wdata = 8'($urandom);
      if ($urandom_range(0, 7) == 0) pin_in = 8'($urandom);
    end
    @(negedge clk); bus_sel = 0;
    idle(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule